// File: doc/BRIEF.md
# Pipelined CORDIC Sine/Cosine Generator

This block turns a binary angle into its cosine and sine using a rotation-mode CORDIC datapath. It uses only shifts, additions and a short table of arctangent constants, so it needs no multiplier. An angle is presented together with a valid strobe. After a fixed number of clock cycles the two fixed-point results appear with their own valid strobe. A new angle may be presented on every clock cycle.

The input angle is an unsigned fraction of a full turn. Before the iterations start, the two top bits fold the angle into the right half-plane. For the second and third quadrants the starting vector is swapped onto the ±y axis, so the same iterations cover the whole circle. The iteration stages are unrolled. The parameter `REG_EVERY` sets how many combinational stages lie between pipeline registers, which trades latency against clock rate. The starting vector is preloaded with the inverse of the CORDIC gain, so the results need no later scaling.

Top module: `cordic_sincos`

## Requirements
- R1: Each accepted angle (in_valid high at a rising edge) produces exactly one cycle of out_valid, LAT = 1 + ceil(ITER/REG_EVERY) rising edges later. LAT is 16 with the defaults. Angles accepted on consecutive cycles give results on consecutive cycles, in the same order.
- R2: For angles whose two top bits are 00 or 11, cos_out and sin_out are each within 64 LSB of round(2^30·cos θ) and round(2^30·sin θ).
- R3: For angles whose two top bits are 01 (90° up to 180°), both outputs meet the same 64 LSB bound.
- R4: For angles whose two top bits are 10 (180° up to 270°), both outputs meet the same 64 LSB bound.
- R5: in_angle is an unsigned fraction of a turn, with 2^32 equal to 360°. So θ = in_angle·2π/2^32, 30° is 0x15555555 and 1° is about 0x00B60B60.
- R6: cos_out and sin_out are two's-complement Q1.30 values, where 2^30 is +1.0, already corrected for the CORDIC gain. Angle 0 gives cos_out ≈ 2^30 and sin_out ≈ 0. While out_valid is high, no output magnitude exceeds 2^30 + 64.
- R7: While rst_n is low, and after it rises, out_valid stays low until an angle accepted after the reset reaches the end of the pipeline. Angles that were in flight when reset was asserted produce no result.
- R8: A cycle with in_valid low produces no out_valid LAT cycles later, whatever value in_angle holds in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Angle strobe |
| in_angle | input | AW (32) | Unsigned binary angle, full turn = 2^32 |
| out_valid | output | 1 | Result strobe |
| cos_out | output | OW (32) | Cosine, signed Q1.30 |
| sin_out | output | OW (32) | Sine, signed Q1.30 |

## Verification
The bench aims at the quadrant edges: 0x3FFFFFFF, 0x40000000, 0x40000001, 0x7FFFFFFF, 0x80000000, 0xBFFFFFFF, 0xC0000000 and 0xFFFFFFFF. A fold with the wrong sign or the wrong axis swap gives results mirrored or rotated by 90° there. Angle 0 and 30° expose a missing or wrong gain preload, which shows up as outputs scaled by about 1.647 or 0.607. Random streams with gaps, and a reset in the middle of a stream, expose a valid strobe that is off by a cycle, that leaks through idle cycles, or that lets a flushed angle through after reset.

// File: rtl/cordic_sincos.sv
`timescale 1ns/1ps
module cordic_sincos #(
  parameter int AW        = 32,
  parameter int OW        = 32,
  parameter int ITER      = 30,
  parameter int REG_EVERY = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] in_angle,
  output logic          out_valid,
  output logic [OW-1:0] cos_out,
  output logic [OW-1:0] sin_out
);
  localparam int  DW = OW + 2;
  localparam int  FB = OW - 2;
  localparam real PI = 3.14159265358979323846;
  localparam logic [AW-1:0] QTR = AW'(1) << (AW - 2);

  function automatic logic signed [AW-1:0] atan_k(int i);
    real r;
    r = $atan(1.0 / (2.0 ** i)) / (2.0 * PI) * (2.0 ** AW);
    return AW'(longint'(r));
  endfunction

  function automatic logic signed [DW-1:0] inv_gain(int n);
    real g;
    g = 1.0;
    for (int i = 0; i < n; i++) g = g * $sqrt(1.0 + 1.0 / (2.0 ** (2 * i)));
    return DW'(longint'((2.0 ** FB) / g));
  endfunction

  localparam logic signed [DW-1:0] XINIT = inv_gain(ITER);

  logic signed [DW-1:0] xf, yf, x0, y0, xs, ys;
  logic signed [AW-1:0] z0, zs;
  logic                 v0;

  always_comb begin
    unique case (in_angle[AW-1:AW-2])
      2'b01:   begin zs = in_angle - QTR; xs = '0; ys = XINIT;  end
      2'b10:   begin zs = in_angle + QTR; xs = '0; ys = -XINIT; end
      default: begin zs = in_angle;       xs = XINIT; ys = '0;  end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) v0 <= 1'b0;
    else        v0 <= in_valid;

  always_ff @(posedge clk) begin
    x0 <= xs;
    y0 <= ys;
    z0 <= zs;
  end

  // R3
  fold_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v0 |-> (z0 <= $signed(QTR) && z0 >= -$signed(QTR)));

  for (genvar i = 0; i < ITER; i++) begin : g_st
    localparam logic signed [AW-1:0] ATAN = atan_k(i);
    logic signed [DW-1:0] xi, yi, xn, yn, xo, yo;
    logic signed [AW-1:0] zi, zn, zo;
    logic                 vi, vo, neg;

    if (i == 0) begin : g_src
      assign xi = x0;
      assign yi = y0;
      assign zi = z0;
      assign vi = v0;
    end else begin : g_src
      assign xi = g_st[i-1].xo;
      assign yi = g_st[i-1].yo;
      assign zi = g_st[i-1].zo;
      assign vi = g_st[i-1].vo;
    end

    assign neg = zi[AW-1];
    assign xn  = neg ? xi + (yi >>> i) : xi - (yi >>> i);
    assign yn  = neg ? yi - (xi >>> i) : yi + (xi >>> i);
    assign zn  = neg ? zi + ATAN : zi - ATAN;

    if (((i + 1) % REG_EVERY == 0) || (i == ITER - 1)) begin : g_reg
      localparam logic signed [AW-1:0] ZLIM = 2 * ATAN + 8;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) vo <= 1'b0;
        else        vo <= vi;
      always_ff @(posedge clk) begin
        xo <= xn;
        yo <= yn;
        zo <= zn;
      end
      // R2
      z_converge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vo |-> (zo <= ZLIM && zo >= -ZLIM));
    end else begin : g_comb
      assign xo = xn;
      assign yo = yn;
      assign zo = zn;
      assign vo = vi;
    end
  end

  assign xf        = g_st[ITER-1].xo;
  assign yf        = g_st[ITER-1].yo;
  assign out_valid = g_st[ITER-1].vo;
  assign cos_out   = xf[OW-1:0];
  assign sin_out   = yf[OW-1:0];

  localparam logic signed [DW-1:0] LIM = (DW'(1) << FB) + DW'(64);

  // R6
  out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (xf <= LIM && xf >= -LIM && yf <= LIM && yf >= -LIM));

  // R7
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);
endmodule

// File: tb/test_cordic_sincos.sv
`timescale 1ns/1ps
module test_cordic_sincos;
  localparam int  ITER = 30;
  localparam int  REG_EVERY = 2;
  localparam int  LAT = 1 + (ITER + REG_EVERY - 1) / REG_EVERY;
  localparam real TOL = 64.0;
  localparam int  NDIR = 14;
  localparam int  NRND = 500;
  localparam int  NS = NDIR + NRND;
  localparam real PI = 3.14159265358979323846;

  logic        clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [31:0] in_angle = '0;
  logic        out_valid;
  logic [31:0] cos_out, sin_out;

  always #2.5 clk = ~clk;

  cordic_sincos #(.AW(32), .OW(32), .ITER(ITER), .REG_EVERY(REG_EVERY)) i_cordic_sincos (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_angle(in_angle),
    .out_valid(out_valid), .cos_out(cos_out), .sin_out(sin_out));

  int          errors = 0, checks = 0;
  bit          done = 1'b0;
  logic [31:0] ang [NS];
  string       tg  [NS];
  bit          hv  [8192];
  int          hidx[8192];

  function automatic string quad_tag(logic [31:0] a);
    case (a[31:30])
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R2";
    endcase
  endfunction

  task automatic chk_val(int k);
    real th, ec, es, dc, ds;
    th = real'(ang[k]) * 2.0 * PI / 4294967296.0;
    ec = $cos(th) * 1073741824.0;
    es = $sin(th) * 1073741824.0;
    dc = real'($signed(cos_out)) - ec;
    ds = real'($signed(sin_out)) - es;
    checks += 2;
    if (dc > TOL || dc < -TOL) begin
      errors++;
      $display("FAIL %s cos angle=%h actual=%0d expected=%0.1f", tg[k], ang[k], $signed(cos_out), ec);
    end
    if (ds > TOL || ds < -TOL) begin
      errors++;
      $display("FAIL %s sin angle=%h actual=%0d expected=%0.1f", tg[k], ang[k], $signed(sin_out), es);
    end
  endtask

  task automatic observe(int n);
    bit ev;
    ev = (n >= LAT) ? hv[n-LAT] : 1'b0;
    checks++;
    if (out_valid !== ev) begin
      errors++;
      $display("FAIL %s out_valid cycle=%0d actual=%b expected=%b", ev ? "R1" : "R8", n, out_valid, ev);
    end
    if (ev && out_valid === 1'b1) chk_val(hidx[n-LAT]);
  endtask

  task automatic run_list(int first, int last, bit gaps);
    int nxt, lastsent;
    nxt = first;
    lastsent = 0;
    for (int n = 0; n < 8000; n++) begin
      @(negedge clk);
      observe(n);
      if (nxt <= last && !(gaps && $urandom_range(0, 4) == 0)) begin
        hv[n] = 1'b1; hidx[n] = nxt; in_valid = 1'b1; in_angle = ang[nxt];
        nxt++; lastsent = n;
      end else begin
        hv[n] = 1'b0; in_valid = 1'b0; in_angle = $urandom;
      end
      if (nxt > last && n >= lastsent + LAT + 2) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic expect_idle(int cycles, string tag);
    for (int n = 0; n < cycles; n++) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
        errors++;
        $display("FAIL %s out_valid during/after reset actual=%b expected=0", tag, out_valid);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    ang[0]  = 32'h0000_0000; tg[0]  = "R6";
    ang[1]  = 32'h1555_5555; tg[1]  = "R5";
    ang[2]  = 32'h4000_0000; tg[2]  = "R3";
    ang[3]  = 32'h8000_0000; tg[3]  = "R4";
    ang[4]  = 32'hC000_0000; tg[4]  = "R2";
    ang[5]  = 32'h2000_0000; tg[5]  = "R2";
    ang[6]  = 32'h3FFF_FFFF; tg[6]  = "R2";
    ang[7]  = 32'h4000_0001; tg[7]  = "R3";
    ang[8]  = 32'h7FFF_FFFF; tg[8]  = "R3";
    ang[9]  = 32'h8000_0001; tg[9]  = "R4";
    ang[10] = 32'hBFFF_FFFF; tg[10] = "R4";
    ang[11] = 32'hFFFF_FFFF; tg[11] = "R2";
    ang[12] = 32'h00B6_0B60; tg[12] = "R5";
    ang[13] = 32'h6000_0000; tg[13] = "R3";
    for (int k = NDIR; k < NS; k++) begin
      if (k % 8 == 0) ang[k] = {2'(k / 8), 30'h0} + 32'($urandom_range(0, 255)) - 32'd128;
      else            ang[k] = $urandom;
      tg[k] = quad_tag(ang[k]);
    end

    // R7: reset state
    expect_idle(4, "R7");
    rst_n = 1'b1;

    // R1, R2..R6: directed angles back to back
    run_list(0, NDIR - 1, 1'b0);
    // R1, R8: random angles with idle gaps and junk angles
    run_list(NDIR, NS - 1, 1'b1);

    // R7: reset with angles in flight
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_angle = ang[k];
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    expect_idle(3, "R7");
    rst_n = 1'b1;
    expect_idle(LAT + 3, "R7");

    // R1/R3: recovery after reset
    run_list(2, 2, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule